// File: doc/BRIEF.md
# Serial Memory Device-Select Front End

This block is the bus-facing slave of a 2048-byte serial memory on a two-wire (I2C) bus. A fast system clock samples the bus clock and data lines through a synchronizer. The block recognises START and STOP conditions and takes in the first byte after a START as a device-select byte. A fixed four-bit prefix must match before the block responds. The next three bits give the top of an 11-bit memory address, and the lowest bit selects read or write.

In write mode the master sends one more byte, the low eight address bits, and then any number of data bytes. Each data byte is stored in the internal array and the address advances. In read mode the block returns bytes from the current address, most significant bit first. The master acknowledges to fetch the next byte or sends a not-acknowledge to end the read. The data line is open-drain: the block either pulls it low or lets it go.

Top module: `serial_mem_select`

## Requirements
- R1: After reset the block releases the data line (sda_pull_o = 0) and waits in the idle state.
- R2: Bytes clocked on the bus before any START are ignored: no acknowledge is given and the line stays released.
- R3: A START is a falling data line while the clock is high, and a STOP is a rising data line while the clock is high. After a STOP the block is idle again and ignores bytes until the next START.
- R4: The select byte is only answered when its bits 7..4 equal 4'b1010. On a mismatch the line stays released for the rest of the transfer, including later bytes, until the next START.
- R5: After a matching select byte, the block pulls the data line low for the whole of the ninth clock pulse.
- R6: In write mode the byte after the select byte supplies address bits 7..0, and each later byte is stored at the current address. Every one of these bytes is acknowledged on its ninth clock.
- R7: The 11-bit address increments after every byte written or sent, and it wraps from 2047 to 0.
- R8: In read mode the block shifts out the byte at the current address MSB first, one bit per clock pulse. It changes its drive of the data line only while the clock is low.
- R9: After a read byte, a master acknowledge (data low on the ninth clock) starts the byte at the next address. A master not-acknowledge releases the line until the next STOP or START.
- R10: A START in the middle of a transfer, whether mid-byte or between bytes, abandons it and begins decoding a fresh select byte.
- R11: Bit 0 of the select byte picks the direction (1 = read, 0 = write). In both directions, bits 3..1 load address bits 10..8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
The assertions assume a well-formed bus. The master never makes a START or STOP while the block is pulling the data line low, and each line level holds for more system clocks than the synchronizer depth, so a change on the data line is never seen in the same sample as a clock edge. The bench keeps to this: every bus phase lasts eight system clocks, data moves only in the middle of the clock-low phase, and START/STOP are issued only after the block has released the line. Under these conditions any change of the block's drive while the clock is high is a design fault, not a bus-race artefact.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

    localparam int MEM_AW   = 11;
    localparam int MEM_DW   = 8;
    localparam int PAGE_W   = MEM_AW - 8;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_PARK
    } bus_st_e;

    typedef struct packed {
        logic [3:0]        prefix;
        logic [PAGE_W-1:0] page;
        logic              rd;
    } sel_byte_t;

    function automatic logic sel_hit(input sel_byte_t b);
        return b.prefix == DEV_PREFIX;
    endfunction

endpackage

// File: rtl/serial_mem_sense.sv
module serial_mem_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    // pipe[SYNC_STAGES-1] is the synchronized level, pipe[SYNC_STAGES] the previous one
    logic [SYNC_STAGES:0] scl_pipe;
    logic [SYNC_STAGES:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[SYNC_STAGES-1];
    assign scl_old = scl_pipe[SYNC_STAGES];
    assign sda_now = sda_pipe[SYNC_STAGES-1];
    assign sda_old = sda_pipe[SYNC_STAGES];

    assign scl_o      = scl_now;
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/serial_mem_store.sv
module serial_mem_store #(
    parameter int AW = serial_mem_pkg::MEM_AW,
    parameter int DW = serial_mem_pkg::MEM_DW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/serial_mem_select.sv
module serial_mem_select
    import serial_mem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int CNT_W = $clog2(MEM_DW + 1);
    localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(MEM_DW);
    localparam logic [CNT_W-1:0] LAST_TX   = CNT_W'(MEM_DW - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

    serial_mem_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    bus_st_e           state;
    logic [CNT_W-1:0]  cnt;
    logic [MEM_DW-1:0] shreg;
    logic [MEM_DW-1:0] txreg;
    logic [MEM_AW-1:0] addr;
    logic              rw;
    logic              drive;
    logic              mst_ack;

    sel_byte_t         sel_v;
    logic [MEM_AW-1:0] addr_nxt;
    logic [MEM_AW-1:0] rd_addr;
    logic [MEM_DW-1:0] rd_data;
    logic              wr_en;

    assign sel_v    = sel_byte_t'(shreg);
    assign addr_nxt = addr + 1'b1;
    assign rd_addr  = (state == ST_RACK) ? addr_nxt : addr;
    assign wr_en    = (state == ST_WDAT) && scl_fall && (cnt == BYTE_DONE) && !start_c && !stop_c;

    serial_mem_store #(.AW(MEM_AW), .DW(MEM_DW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_data (shreg),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            txreg   <= '0;
            addr    <= '0;
            rw      <= 1'b0;
            drive   <= 1'b0;
            mst_ack <= 1'b0;
        end else if (start_c) begin
            state <= ST_SEL;
            cnt   <= '0;
            drive <= 1'b0;
        end else if (stop_c) begin
            state <= ST_IDLE;
            cnt   <= '0;
            drive <= 1'b0;
        end else begin
            unique case (state)
                ST_SEL, ST_WADR, ST_WDAT: begin
                    if (scl_rise && cnt != BYTE_DONE) begin
                        shreg <= {shreg[MEM_DW-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (scl_fall && cnt == BYTE_DONE) begin
                        cnt <= '0;
                        if (state == ST_SEL) begin
                            if (sel_hit(sel_v)) begin
                                addr[MEM_AW-1:8] <= sel_v.page;
                                rw               <= sel_v.rd;
                                drive            <= 1'b1;
                                state            <= ST_SEL_ACK;
                            end else begin
                                state <= ST_PARK;
                            end
                        end else if (state == ST_WADR) begin
                            addr[7:0] <= shreg;
                            drive     <= 1'b1;
                            state     <= ST_WADR_ACK;
                        end else begin
                            drive <= 1'b1;
                            state <= ST_WDAT_ACK;
                        end
                    end
                end
                ST_SEL_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            txreg <= rd_data;
                            drive <= ~rd_data[MEM_DW-1];
                            state <= ST_RDAT;
                        end else begin
                            drive <= 1'b0;
                            state <= ST_WADR;
                        end
                    end
                end
                ST_WADR_ACK: begin
                    if (scl_fall) begin
                        drive <= 1'b0;
                        state <= ST_WDAT;
                    end
                end
                ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        drive <= 1'b0;
                        addr  <= addr_nxt;
                        state <= ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (cnt == LAST_TX) begin
                            drive <= 1'b0;
                            cnt   <= '0;
                            state <= ST_RACK;
                        end else begin
                            txreg <= {txreg[MEM_DW-2:0], 1'b0};
                            drive <= ~txreg[MEM_DW-2];
                            cnt   <= cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mst_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        addr <= addr_nxt;
                        if (mst_ack) begin
                            txreg <= rd_data;
                            drive <= ~rd_data[MEM_DW-1];
                            state <= ST_RDAT;
                        end else begin
                            state <= ST_PARK;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull_o = drive;

    // R8: the drive only moves while the synchronized clock is low
    p_drive_moves_low_r8: assert property (@(posedge clk) disable iff (rst)
        (drive != $past(drive)) |-> !scl_s);

    // R4: an acknowledge of a select byte only follows a matching prefix
    p_ack_needs_prefix_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(drive) && $past(state) == ST_SEL) |-> shreg[7:4] == DEV_PREFIX);

    // R4: a rejected or finished transfer keeps the line released
    p_park_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PARK) |-> !drive);

    // R3: a STOP leaves the block idle and released
    p_stop_idles_r3: assert property (@(posedge clk) disable iff (rst)
        $past(stop_c) |-> (state == ST_IDLE && !drive));

    // R10: a START always restarts select decoding from bit zero
    p_start_restarts_r10: assert property (@(posedge clk) disable iff (rst)
        $past(start_c) |-> (state == ST_SEL && cnt == '0 && !drive));

    // R6: writes to the array happen only while a write data byte completes
    p_write_only_in_wdat_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (state == ST_WDAT && !rw));

endmodule

// File: tb/serial_mem_select_bench.sv
module serial_mem_select_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;
    assign sda_line = sda_m & ~sda_pull;

    serial_mem_select u_serial_mem_select (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull)
    );

    int checks = 0;
    int errors = 0;
    int scl_high_moves = 0;
    int free_violations = 0;
    logic expect_free = 1'b0;
    logic prev_pull = 1'b0;
    logic done = 1'b0;
    logic [7:0] ref_mem [0:2047];

    // per-clock reference: drive must stay put while the bus clock is high (R8)
    // and must be off whenever the model expects a released line (R2, R4, R9)
    always @(negedge clk) begin
        if (!rst) begin
            if (sda_pull !== prev_pull && scl_m) scl_high_moves++;
            if (expect_free && sda_pull !== 1'b0) free_violations++;
        end
        prev_pull <= sda_pull;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic q();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 1'b0; q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; q(); sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic bit_x(input logic b, output logic s);
        scl_m = 1'b0; q(); sda_m = b; q(); scl_m = 1'b1; q(); s = sda_line; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_x(b[i], s);
        bit_x(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_x(1'b1, s);
            d = {d[6:0], s};
        end
        bit_x(!mack, s);
    endtask

    // START, write select with a10..a8, then low address byte
    task automatic point(input logic [10:0] a, input string req);
        logic k;
        bus_start();
        send_byte({4'b1010, a[10:8], 1'b0}, k);
        check(req, k, 1'b1, "select ack");
        send_byte(a[7:0], k);
        check("R6", k, 1'b1, "address byte ack");
    endtask

    task automatic write_at(input logic [10:0] a, input logic [7:0] d, input string req);
        logic k;
        send_byte(d, k);
        check(req, k, 1'b1, "data byte ack");
        ref_mem[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic k;
        logic s;
        logic [7:0] d;
        repeat (10) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q();
        check("R1", sda_pull, 1'b0, "released after reset");

        // R2: no START yet
        expect_free = 1'b1;
        send_byte(8'hA0, k);
        check("R2", k, 1'b0, "byte before START not acked");
        expect_free = 1'b0;

        // R6/R11: write page 000 and page 011
        point(11'h010, "R5");
        write_at(11'h010, 8'h77, "R6");
        bus_stop();
        point(11'h310, "R11");
        write_at(11'h310, 8'h5A, "R6");
        write_at(11'h311, 8'hC3, "R7");
        bus_stop();

        // R8/R9/R10: repeated START into read
        point(11'h310, "R10");
        bus_start();
        send_byte(8'hA7, k);
        check("R11", k, 1'b1, "read select ack");
        recv_byte(1'b1, d);
        check("R8", d, ref_mem[11'h310], "read byte 0x310");
        recv_byte(1'b0, d);
        check("R9", d, ref_mem[11'h311], "byte after master ack");
        expect_free = 1'b1;
        bit_x(1'b1, s);
        check("R9", s, 1'b1, "line released after NACK");
        bus_stop();
        expect_free = 1'b0;

        // R6: page bits separate 0x010 from 0x310
        point(11'h010, "R5");
        bus_start();
        send_byte(8'hA1, k);
        check("R11", k, 1'b1, "read select page 000");
        recv_byte(1'b0, d);
        check("R6", d, ref_mem[11'h010], "read byte 0x010");
        bus_stop();

        // R4: wrong prefix
        expect_free = 1'b1;
        bus_start();
        send_byte(8'hB6, k);
        check("R4", k, 1'b0, "mismatched prefix not acked");
        send_byte(8'h00, k);
        check("R4", k, 1'b0, "later byte after mismatch not acked");
        expect_free = 1'b0;
        bus_start();
        send_byte(8'hA6, k);
        check("R4", k, 1'b1, "next START with prefix acked");
        bus_stop();

        // R3: after STOP, bytes are ignored
        expect_free = 1'b1;
        send_byte(8'hA0, k);
        check("R3", k, 1'b0, "byte after STOP not acked");
        expect_free = 1'b0;

        // R10: START in the middle of a byte
        bus_start();
        bit_x(1'b1, s); bit_x(1'b0, s); bit_x(1'b1, s); bit_x(1'b0, s);
        bus_start();
        send_byte(8'hA6, k);
        check("R10", k, 1'b1, "select after mid-byte START acked");
        bus_stop();

        // R7: wrap at 2047 on write and on read
        point(11'h7FF, "R5");
        write_at(11'h7FF, 8'h11, "R7");
        write_at(11'h000, 8'h22, "R7");
        bus_stop();
        point(11'h7FF, "R5");
        bus_start();
        send_byte(8'hAF, k);
        check("R11", k, 1'b1, "read select page 111");
        recv_byte(1'b1, d);
        check("R7", d, 8'h11, "byte at 2047");
        recv_byte(1'b0, d);
        check("R7", d, 8'h22, "read wraps to 0");
        bus_stop();
        point(11'h000, "R5");
        bus_start();
        send_byte(8'hA1, k);
        check("R11", k, 1'b1, "read select page 000");
        recv_byte(1'b0, d);
        check("R7", d, 8'h22, "write wrapped to 0");
        bus_stop();

        q();
        check("R8", scl_high_moves, 0, "drive changes while clock high");
        check("R9", free_violations, 0, "cycles driven when line must be free");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule